// File: doc/BRIEF.md
# Page-buffered EEPROM write controller

This block sits behind a two-wire serial slave engine and turns the byte-level events of a write transaction into a single page commit. The engine reports a transaction start, a control byte addressed to this device, the array address byte, each data byte and the stop condition. The controller answers every byte with an acknowledge decision, one cycle after the event. It gathers the data bytes in a page buffer and, once the stop arrives, runs an internal write cycle. During that cycle it drives the memory array write port and refuses all traffic.

The logical address is a bank bit together with an 8-bit offset. One data transaction always stays inside one 16-byte page. The offset's low four bits step on each byte and wrap inside the page. A four-bit mask protects half-bank blocks: for each block it says whether writes are refused. The write-cycle length is a count of clock cycles, so a bench can shorten it.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, ack_valid_o, ack_o, busy_o and mem_we_o are low and no address byte is held.
- R2: A control, address or data event in cycle k gives ack_valid_o high in cycle k+1, with ack_o carrying the decision. While idle, control and address bytes are acknowledged.
- R3: An accepted data byte is stored in the page slot given by the low 4 offset bits. Those bits then advance modulo 16. The upper 4 offset bits and the bank bit latched with the address byte do not change.
- R4: When more than 16 data bytes arrive before the stop, the pointer wraps inside the page, and each slot keeps the last byte written to it.
- R5: A stop in cycle k, after at least one accepted data byte, raises busy_o from cycle k+1 for exactly WC_CYCLES cycles. A stop with no accepted data starts no cycle.
- R6: In cycle n of the write cycle (n = 0..15), the write port addresses slot n of the latched page as {bank, upper offset, n}. mem_we_o is high only for slots that received data, so all other bytes of the page keep their contents.
- R7: While busy_o is high, every control, address and data event is answered with ack_o low. Start, stop and data events change nothing.
- R8: The protected block index is {bank bit, offset bit 7}, and wp_mask_i bit i protects block i. A data byte aimed at a protected block is NACKed and the buffered bytes are discarded. No write cycle follows, and the next command is accepted at once.
- R9: A start before the stop discards the buffered bytes, so a following stop writes nothing.
- R10: A data byte with no address byte since the last start is NACKed and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| ctrl_valid_i | input | 1 | Control byte for this device received |
| addr_valid_i | input | 1 | Array address byte received on byte_i |
| data_valid_i | input | 1 | Data byte received on byte_i |
| byte_i | input | DATA_W | Received byte |
| bank_i | input | 1 | Currently selected bank |
| wp_mask_i | input | 4 | Per-block write-protect mask |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | OFFS_W+1 | Array write address {bank, offset} |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The bench builds the block with WC_CYCLES set to 40 and keeps the 16-byte page and 8-bit offset. The short cycle lets several full commits run back to back. It also brings into reach the polling window, in which control bytes and start or stop events land while busy_o is high, as well as the exact cycle busy_o falls. The full page at 16 bytes covers in-page wrap from a mid-page offset and overruns past 16 bytes. The mask covers both a protected half of bank 1 and its unprotected neighbour.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } pwc_state_e;

  localparam int unsigned NBLK = 4;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (hit) begin
        slot_q[g] <= wr_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/pwc_wc_timer.sv
module pwc_wc_timer #(
  parameter int unsigned WC_CYCLES  = 5000,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W     = $clog2(WC_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             slot_live_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CNT_W'(WC_CYCLES - 1)) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign slot_o      = cnt_q[IDX_W-1:0];
  assign slot_live_o = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
endmodule

// File: rtl/pwc_wp_check.sv
module pwc_wp_check
  import pwc_pkg::*;
(
  input  logic            bank_i,
  input  logic            offs_msb_i,
  input  logic [NBLK-1:0] mask_i,
  output logic            hit_o
);
  logic [1:0] blk;
  assign blk   = {bank_i, offs_msb_i};
  assign hit_o = mask_i[blk];
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OFFS_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned WC_CYCLES  = 5000,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
  localparam int unsigned HI_W      = OFFS_W - IDX_W,
  localparam int unsigned ADDR_W    = OFFS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ctrl_valid_i,
  input  logic              addr_valid_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              bank_i,
  input  logic [NBLK-1:0]   wp_mask_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  pwc_state_e       state_q;
  logic             bank_q;
  logic [HI_W-1:0]  page_q;
  logic [IDX_W-1:0] ptr_q;
  logic             ack_valid_q, ack_q;

  logic             busy, wp_hit, recv;
  logic             buf_clr, buf_wr, any_vld, rd_vld, tmr_go, slot_live;
  logic [IDX_W-1:0] slot;
  logic [DATA_W-1:0] rd_data;
  logic             ack_d;

  assign recv = (state_q == ST_RECV);

  pwc_wp_check u_wp (
    .bank_i     (bank_q),
    .offs_msb_i (page_q[HI_W-1]),
    .mask_i     (wp_mask_i),
    .hit_o      (wp_hit)
  );

  // events are ignored entirely while the write cycle runs
  assign buf_wr  = !busy && data_valid_i && recv && !wp_hit;
  assign buf_clr = !busy && (start_i || addr_valid_i || (data_valid_i && recv && wp_hit));
  assign tmr_go  = !busy && stop_i && recv && any_vld;

  pwc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_i      (buf_wr),
    .wr_idx_i  (ptr_q),
    .wr_data_i (byte_i),
    .rd_idx_i  (slot),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  pwc_wc_timer #(.WC_CYCLES(WC_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (tmr_go),
    .busy_o      (busy),
    .slot_o      (slot),
    .slot_live_o (slot_live)
  );

  always_comb begin
    ack_d = 1'b0;
    if (!busy) begin
      if (ctrl_valid_i || addr_valid_i) ack_d = 1'b1;
      else if (data_valid_i)            ack_d = recv && !wp_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bank_q      <= 1'b0;
      page_q      <= '0;
      ptr_q       <= '0;
      ack_valid_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      ack_valid_q <= ctrl_valid_i || addr_valid_i || data_valid_i;
      ack_q       <= ack_d;
      if (!busy) begin
        if (start_i || stop_i) begin
          state_q <= ST_IDLE;
        end else if (addr_valid_i) begin
          state_q <= ST_RECV;
          bank_q  <= bank_i;
          page_q  <= byte_i[OFFS_W-1:IDX_W];
          ptr_q   <= byte_i[IDX_W-1:0];
        end else if (data_valid_i && recv) begin
          if (wp_hit) state_q <= ST_IDLE;
          else        ptr_q   <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_o       = ack_q;
  assign busy_o      = busy;
  assign mem_we_o    = slot_live && rd_vld;
  assign mem_addr_o  = {bank_q, page_q, slot};
  assign mem_wdata_o = rd_data;
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              ctrl_valid_i,
  input logic              addr_valid_i,
  input logic              data_valid_i,
  input logic              ack_valid_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  a_r2_ack_follows_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ctrl_valid_i || addr_valid_i || data_valid_i));

  a_r3_page_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:IDX_W]));

  a_r5_cycle_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  a_r6_we_inside_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  a_r7_nack_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && $past(busy_o)) |-> !ack_o);
endmodule

bind page_write_ctrl pwc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .ctrl_valid_i (ctrl_valid_i),
  .addr_valid_i (addr_valid_i),
  .data_valid_i (data_valid_i),
  .ack_valid_o  (ack_valid_o),
  .ack_o        (ack_o),
  .busy_o       (busy_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, stop, ctrl_v, addr_v, data_v, bank;
  logic [7:0] byt;
  logic [3:0] wp;
  logic ack_valid, ack, busy, we;
  logic [8:0] maddr;
  logic [7:0] mdata;

  always #5 clk = ~clk;

  page_write_ctrl #(.WC_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .ctrl_valid_i(ctrl_v), .addr_valid_i(addr_v), .data_valid_i(data_v),
    .byte_i(byt), .bank_i(bank), .wp_mask_i(wp),
    .ack_valid_o(ack_valid), .ack_o(ack), .busy_o(busy),
    .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(mdata)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int  m_state, m_bank, m_page, m_ptr, m_cnt;
  int  mbuf [16];
  bit  mvld [16];
  bit  m_busy;
  bit  e_ackv, e_ack, e_we;
  int  e_addr, e_data;

  function automatic bit any_valid();
    foreach (mvld[i]) if (mvld[i]) return 1;
    return 0;
  endfunction

  function automatic void clr_buf();
    foreach (mvld[i]) mvld[i] = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_bank = 0; m_page = 0; m_ptr = 0; m_cnt = 0; m_busy = 0;
      clr_buf();
      foreach (mbuf[i]) mbuf[i] = 0;
      e_ackv = 0; e_ack = 0; e_we = 0; e_addr = 0; e_data = 0;
    end else begin
      e_ackv = ctrl_v | addr_v | data_v;
      e_ack  = 0;
      if (m_busy) begin
        if (m_cnt == WC - 1) begin m_busy = 0; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (start) begin clr_buf(); m_state = 0; end
        if (ctrl_v) e_ack = 1;
        if (addr_v) begin
          e_ack = 1; m_state = 1; m_bank = bank;
          m_page = byt >> 4; m_ptr = byt & 15; clr_buf();
        end
        if (data_v) begin
          if (m_state == 1) begin
            if (wp[m_bank * 2 + (m_page >> 3)]) begin
              clr_buf(); m_state = 0;
            end else begin
              mbuf[m_ptr] = byt; mvld[m_ptr] = 1;
              m_ptr = (m_ptr + 1) % 16; e_ack = 1;
            end
          end
        end
        if (stop) begin
          if (m_state == 1 && any_valid()) begin m_busy = 1; m_cnt = 0; end
          m_state = 0;
        end
      end
      e_we   = m_busy && m_cnt < 16 && mvld[m_cnt % 16];
      e_addr = m_bank * 256 + m_page * 16 + (m_cnt % 16);
      e_data = mbuf[m_cnt % 16];
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("ack_valid", ack_valid, e_ackv);
      if (e_ackv) chk("ack", ack, e_ack);
      chk("busy", busy, m_busy);
      chk("mem_we", we, e_we);
      if (e_we) begin
        chk("mem_addr", maddr, e_addr);
        chk("mem_wdata", mdata, e_data);
      end
    end
  end

  // kinds: 0 start, 1 ctrl, 2 addr, 3 data, 4 stop
  task automatic evt(input int kind, input logic [7:0] b);
    @(negedge clk);
    start = (kind == 0); ctrl_v = (kind == 1); addr_v = (kind == 2);
    data_v = (kind == 3); stop = (kind == 4); byt = b;
    @(negedge clk);
    start = 0; ctrl_v = 0; addr_v = 0; data_v = 0; stop = 0;
  endtask

  task automatic wr_head(input logic [7:0] a);
    evt(0, 0); evt(1, 8'hA0); evt(2, a);
  endtask

  task automatic settle();
    repeat (WC + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    start = 0; stop = 0; ctrl_v = 0; addr_v = 0; data_v = 0;
    byt = 0; bank = 0; wp = 4'b0000;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    cur_req = "R1";
    chk("reset outputs", {ack_valid, ack, busy, we}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 / R5 / R6: single byte write
    cur_req = "R2";
    wr_head(8'h25);
    cur_req = "R5";
    evt(3, 8'hA5); evt(4, 0);
    // R7: polling and ignored events during the cycle
    cur_req = "R7";
    evt(0, 0); evt(1, 8'hA0); evt(2, 8'h40); evt(3, 8'h11); evt(4, 0);
    settle();
    cur_req = "R6";
    evt(0, 0); evt(1, 8'hA0); evt(4, 0);

    // R3: mid-page start wrapping inside page 0x3_
    cur_req = "R3";
    wr_head(8'h3A);
    for (int i = 0; i < 8; i++) evt(3, 8'h50 + 8'(i));
    evt(4, 0); settle();

    // R4: 20 bytes into page 0x7_ of bank 1
    cur_req = "R4";
    bank = 1;
    wr_head(8'h70);
    for (int i = 0; i < 20; i++) evt(3, 8'hC0 + 8'(i));
    evt(4, 0); settle();

    // R8: block 2 (bank 1, offset bit7 = 0) protected
    cur_req = "R8";
    wp = 4'b0100;
    wr_head(8'h10);
    evt(3, 8'h77); evt(3, 8'h78); evt(4, 0);
    repeat (4) @(negedge clk);
    wr_head(8'h90);
    evt(3, 8'h99); evt(4, 0); settle();
    bank = 0;
    wr_head(8'h10);
    evt(3, 8'h12); evt(4, 0); settle();

    // R9: start before stop discards buffer
    cur_req = "R9";
    wr_head(8'h44);
    evt(3, 8'h01); evt(3, 8'h02);
    evt(0, 0); evt(1, 8'hA1); evt(4, 0);
    repeat (6) @(negedge clk);

    // R10: data without address byte
    cur_req = "R10";
    evt(0, 0); evt(1, 8'hA0); evt(3, 8'h33); evt(4, 0);
    repeat (6) @(negedge clk);

    // R5: address only, no data -> no cycle
    cur_req = "R5";
    wr_head(8'h08); evt(4, 0);
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule